// File: doc/BRIEF.md
# Integer Execute Unit with Signed-Overflow Trap

This block is the integer execute stage of a 32-bit RISC pipeline. On each cycle where `issue_vld` is high it takes two source operands, a 4-bit operation selector and a 5-bit immediate shift amount. One clock edge later it presents the result with a valid strobe. The unit covers addition and subtraction in two flavours. The trapping form raises `ovf_trap` on signed overflow. The wrapping form never traps. The unit also performs left and right shifts, logical and arithmetic, and right rotation, each with either an immediate amount or a register amount. Finally it counts the leading zero bits or the leading one bits of the first operand.

When a trapping operation overflows, the unit still returns the wrapped value on `res_data`, but it holds `rd_wen` low so the surrounding pipeline commits nothing to the destination register. The exception path can then take over. Multiply, divide, register storage and exception vectoring live elsewhere.

Top module: `int_exec_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `res_vld`, `res_data`, `ovf_trap` and `rd_wen` to zero at the next rising edge.
- R2: An operation issued with `issue_vld` high at a rising edge appears on `res_data` with `res_vld` high right after that edge. A cycle without issue leaves `res_vld`, `ovf_trap` and `rd_wen` low after the following edge.
- R3: Opcode 0 (trapping add) returns `opnd_a + opnd_b` modulo 2^32. It sets `ovf_trap` exactly when both operands have equal sign bits (bit 31) and the sum's sign bit differs from them.
- R4: Opcode 2 (trapping subtract) returns `opnd_a - opnd_b` modulo 2^32. It sets `ovf_trap` exactly when the operand sign bits differ and the difference's sign bit differs from that of `opnd_a`.
- R5: Opcode 1 (wrapping add) and opcode 3 (wrapping subtract) return the same modular results as opcodes 0 and 2 and never set `ovf_trap`.
- R6: `rd_wen` is high with every valid result, except when `ovf_trap` is high; then `rd_wen` is low.
- R7: Opcodes 4 and 8 shift `opnd_a` left, and opcodes 5 and 9 shift it right; both fill with zeros. Opcodes 4 to 7 take the amount from `shamt_imm`. Opcodes 8 to 11 take it from bits 4:0 of `opnd_b` only and ignore all higher bits of `opnd_b`.
- R8: Opcodes 6 and 10 shift `opnd_a` right and fill the vacated upper bits with copies of bit 31.
- R9: Opcodes 7 and 11 rotate `opnd_a` right by n: bit i of the result is bit (i+n) mod 32 of `opnd_a`. An amount of zero returns `opnd_a` unchanged.
- R10: Opcode 12 returns the number of consecutive zero bits of `opnd_a` counted down from bit 31, and 32 for an all-zero operand.
- R11: Opcode 13 returns the number of consecutive one bits of `opnd_a` counted down from bit 31, and 32 for an all-ones operand.
- R12: Opcodes 14 and 15 return zero with `ovf_trap` low and `rd_wen` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| issue_vld | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation selector (encodings in R3 to R12) |
| opnd_a | input | 32 | First source operand, the value that is shifted or counted |
| opnd_b | input | 32 | Second source operand; bits 4:0 supply the register shift amount |
| shamt_imm | input | 5 | Immediate shift or rotate amount |
| res_vld | output | 1 | Result valid strobe |
| res_data | output | 32 | Registered result |
| ovf_trap | output | 1 | Signed-overflow exception from a trapping add or subtract |
| rd_wen | output | 1 | Destination write enable; low when the result must not be committed |

## Verification
The arithmetic opcodes are swept over every ordered pair drawn from a set of boundary values: zero, one, the largest and smallest signed numbers, all ones, and mid-range values of both signs. The sweep separates the sign-agreement overflow rule from the sign-disagreement rule and shows that the wrapping forms stay silent on the same operands. Every shift and rotate opcode is run at all 32 amounts on operands with a set and a clear sign bit. The register forms are driven with garbage in the upper bits of `opnd_b`, and the immediate forms with an unrelated amount in `opnd_b`. This exposes a wrong amount source, a wrong fill bit or a rotate that drops bits. The leading-bit counters see one operand per position of the first differing bit, plus the all-zero and all-ones operands, which pins down every count from 0 to 32.

// File: rtl/iex_pkg.sv
package iex_pkg;

    localparam int IEX_XLEN = 32;

    typedef enum logic [3:0] {
        OP_ADD_TRAP = 4'd0,
        OP_ADD_WRAP = 4'd1,
        OP_SUB_TRAP = 4'd2,
        OP_SUB_WRAP = 4'd3,
        OP_SLL_IMM  = 4'd4,
        OP_SRL_IMM  = 4'd5,
        OP_SRA_IMM  = 4'd6,
        OP_ROR_IMM  = 4'd7,
        OP_SLL_REG  = 4'd8,
        OP_SRL_REG  = 4'd9,
        OP_SRA_REG  = 4'd10,
        OP_ROR_REG  = 4'd11,
        OP_CNT_ZERO = 4'd12,
        OP_CNT_ONE  = 4'd13
    } iex_op_e;

    typedef enum logic [1:0] {
        SHK_LEFT  = 2'd0,
        SHK_RLOG  = 2'd1,
        SHK_RARI  = 2'd2,
        SHK_ROT   = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic        use_add;
        logic        is_sub;
        logic        trap_en;
        logic        use_shift;
        logic        amt_from_reg;
        shift_kind_e sh_kind;
        logic        use_cnt;
        logic        cnt_ones;
    } iex_ctrl_t;

    function automatic iex_ctrl_t iex_decode(input logic [3:0] code);
        iex_ctrl_t c;
        c = '0;
        case (iex_op_e'(code))
            OP_ADD_TRAP: begin c.use_add = 1'b1; c.trap_en = 1'b1; end
            OP_ADD_WRAP: c.use_add = 1'b1;
            OP_SUB_TRAP: begin c.use_add = 1'b1; c.is_sub = 1'b1; c.trap_en = 1'b1; end
            OP_SUB_WRAP: begin c.use_add = 1'b1; c.is_sub = 1'b1; end
            OP_SLL_IMM:  begin c.use_shift = 1'b1; c.sh_kind = SHK_LEFT; end
            OP_SRL_IMM:  begin c.use_shift = 1'b1; c.sh_kind = SHK_RLOG; end
            OP_SRA_IMM:  begin c.use_shift = 1'b1; c.sh_kind = SHK_RARI; end
            OP_ROR_IMM:  begin c.use_shift = 1'b1; c.sh_kind = SHK_ROT;  end
            OP_SLL_REG:  begin c.use_shift = 1'b1; c.amt_from_reg = 1'b1; c.sh_kind = SHK_LEFT; end
            OP_SRL_REG:  begin c.use_shift = 1'b1; c.amt_from_reg = 1'b1; c.sh_kind = SHK_RLOG; end
            OP_SRA_REG:  begin c.use_shift = 1'b1; c.amt_from_reg = 1'b1; c.sh_kind = SHK_RARI; end
            OP_ROR_REG:  begin c.use_shift = 1'b1; c.amt_from_reg = 1'b1; c.sh_kind = SHK_ROT;  end
            OP_CNT_ZERO: c.use_cnt = 1'b1;
            OP_CNT_ONE:  begin c.use_cnt = 1'b1; c.cnt_ones = 1'b1; end
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/iex_addsub.sv
module iex_addsub #(
    parameter int XLEN = iex_pkg::IEX_XLEN
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            is_sub,
    input  logic            trap_en,
    output logic [XLEN-1:0] sum,
    output logic            ovf
);
    logic [XLEN-1:0] b_eff;
    logic            same_sign_in;

    always_comb begin
        b_eff        = is_sub ? ~b : b;
        sum          = a + b_eff + {{(XLEN-1){1'b0}}, is_sub};
        // Overflow only when the effective addends agree in sign and the sum disagrees
        same_sign_in = (a[XLEN-1] == b_eff[XLEN-1]);
        ovf          = trap_en & same_sign_in & (sum[XLEN-1] != a[XLEN-1]);
    end
endmodule

// File: rtl/iex_shifter.sv
module iex_shifter #(
    parameter int XLEN = iex_pkg::IEX_XLEN,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]           din,
    input  logic [SHW-1:0]            amt,
    input  iex_pkg::shift_kind_e      kind,
    output logic [XLEN-1:0]           dout
);
    import iex_pkg::*;

    // Rotate built as a logarithmic stage chain
    logic [XLEN-1:0] rot_stage [SHW+1];
    assign rot_stage[0] = din;

    for (genvar k = 0; k < SHW; k++) begin : g_rot
        localparam int STEP = 1 << k;
        assign rot_stage[k+1] = amt[k]
            ? {rot_stage[k][STEP-1:0], rot_stage[k][XLEN-1:STEP]}
            : rot_stage[k];
    end

    always_comb begin
        case (kind)
            SHK_LEFT: dout = din << amt;
            SHK_RLOG: dout = din >> amt;
            SHK_RARI: dout = $unsigned($signed(din) >>> amt);
            default:  dout = rot_stage[SHW];
        endcase
    end
endmodule

// File: rtl/iex_lead_count.sv
module iex_lead_count #(
    parameter int XLEN = iex_pkg::IEX_XLEN,
    localparam int CW = $clog2(XLEN) + 1
) (
    input  logic [XLEN-1:0] vec,
    output logic [CW-1:0]   count
);
    // Counts leading zeros; the caller inverts the operand for leading ones
    always_comb begin
        count = CW'(XLEN);
        for (int i = 0; i < XLEN; i++) begin
            if (vec[i]) count = CW'(XLEN - 1 - i);
        end
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
    parameter int XLEN = iex_pkg::IEX_XLEN,
    localparam int SHW = $clog2(XLEN),
    localparam int CW  = SHW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_vld,
    input  logic [3:0]      op_code,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [SHW-1:0]  shamt_imm,
    output logic            res_vld,
    output logic [XLEN-1:0] res_data,
    output logic            ovf_trap,
    output logic            rd_wen
);
    import iex_pkg::*;

    iex_ctrl_t       ctrl;
    logic [XLEN-1:0] as_sum;
    logic            as_ovf;
    logic [SHW-1:0]  sh_amt;
    logic [XLEN-1:0] sh_out;
    logic [XLEN-1:0] cnt_in;
    logic [CW-1:0]   cnt_out;
    logic [XLEN-1:0] nxt_data;
    logic            nxt_ovf;

    always_comb begin
        ctrl   = iex_decode(op_code);
        sh_amt = ctrl.amt_from_reg ? opnd_b[SHW-1:0] : shamt_imm;
        cnt_in = ctrl.cnt_ones ? ~opnd_a : opnd_a;
    end

    iex_addsub #(.XLEN(XLEN)) u_addsub (
        .a       (opnd_a),
        .b       (opnd_b),
        .is_sub  (ctrl.is_sub),
        .trap_en (ctrl.trap_en),
        .sum     (as_sum),
        .ovf     (as_ovf)
    );

    iex_shifter #(.XLEN(XLEN)) u_shifter (
        .din  (opnd_a),
        .amt  (sh_amt),
        .kind (ctrl.sh_kind),
        .dout (sh_out)
    );

    iex_lead_count #(.XLEN(XLEN)) u_lcount (
        .vec   (cnt_in),
        .count (cnt_out)
    );

    always_comb begin
        nxt_data = '0;
        nxt_ovf  = 1'b0;
        if (ctrl.use_add) begin
            nxt_data = as_sum;
            nxt_ovf  = as_ovf;
        end else if (ctrl.use_shift) begin
            nxt_data = sh_out;
        end else if (ctrl.use_cnt) begin
            nxt_data = {{(XLEN-CW){1'b0}}, cnt_out};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld  <= 1'b0;
            res_data <= '0;
            ovf_trap <= 1'b0;
            rd_wen   <= 1'b0;
        end else begin
            res_vld <= issue_vld;
            if (issue_vld) begin
                res_data <= nxt_data;
                ovf_trap <= nxt_ovf;
                rd_wen   <= ~nxt_ovf;
            end else begin
                ovf_trap <= 1'b0;
                rd_wen   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst,
    input logic            issue_vld,
    input logic [3:0]      op_code,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic [SHW-1:0]  shamt_imm,
    input logic            res_vld,
    input logic [XLEN-1:0] res_data,
    input logic            ovf_trap,
    input logic            rd_wen
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_vld && res_data == '0 && !ovf_trap && !rd_wen));

    // R2
    issue_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        issue_vld |=> res_vld);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !issue_vld |=> (!res_vld && !ovf_trap && !rd_wen));

    // R3
    add_trap_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && op_code == 4'd0) |=>
            (ovf_trap == (($past(opnd_a[XLEN-1]) == $past(opnd_b[XLEN-1])) &&
                          (res_data[XLEN-1] != $past(opnd_a[XLEN-1])))));

    // R4
    sub_trap_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && op_code == 4'd2) |=>
            (ovf_trap == (($past(opnd_a[XLEN-1]) != $past(opnd_b[XLEN-1])) &&
                          (res_data[XLEN-1] != $past(opnd_a[XLEN-1])))));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && (op_code == 4'd1 || op_code == 4'd3)) |=> !ovf_trap);

    // R6
    trap_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |-> !rd_wen);

    // R6
    valid_write_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !ovf_trap) |-> rd_wen);

    // R9
    rot_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && op_code == 4'd7 && shamt_imm == '0) |=> (res_data == $past(opnd_a)));

    // R10
    clz_all_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && op_code == 4'd12 && opnd_a == '0) |=> (res_data == XLEN));

    // R11
    clo_all_one_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && op_code == 4'd13 && opnd_a == '1) |=> (res_data == XLEN));

    // R12
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_vld && op_code >= 4'd14) |=> (res_data == '0 && !ovf_trap && rd_wen));
endmodule

bind int_exec_unit int_exec_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .issue_vld (issue_vld),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .shamt_imm (shamt_imm),
    .res_vld   (res_vld),
    .res_data  (res_data),
    .ovf_trap  (ovf_trap),
    .rd_wen    (rd_wen)
);

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_vld = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt_imm = '0;
    logic        res_vld;
    logic [31:0] res_data;
    logic        ovf_trap;
    logic        rd_wen;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    int_exec_unit i_int_exec_unit (
        .clk       (clk),
        .rst       (rst),
        .issue_vld (issue_vld),
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .shamt_imm (shamt_imm),
        .res_vld   (res_vld),
        .res_data  (res_data),
        .ovf_trap  (ovf_trap),
        .rd_wen    (rd_wen)
    );

    function automatic string req_of(input int op);
        case (op)
            0: return "R3";
            1, 3: return "R5";
            2: return "R4";
            4, 5, 8, 9: return "R7";
            6, 10: return "R8";
            7, 11: return "R9";
            12: return "R10";
            13: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh, output logic [31:0] r, output logic ov);
        longint sa, sb, s;
        int n;
        logic [63:0] dbl;
        r  = '0;
        ov = 1'b0;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        n  = (op >= 8) ? int'(b[4:0]) : int'(sh);
        case (op)
            0, 1: begin
                s = sa + sb;
                r = a + b;
                ov = (op == 0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            2, 3: begin
                s = sa - sb;
                r = a - b;
                ov = (op == 2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4, 8: for (int i = 0; i < 32; i++) r[i] = (i >= n) ? a[i-n] : 1'b0;
            5, 9: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : 1'b0;
            6, 10: for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : a[31];
            7, 11: begin dbl = {a, a} >> n; r = dbl[31:0]; end
            12: begin
                int c = 0;
                for (int i = 31; i >= 0 && !a[i]; i--) c++;
                r = 32'(c);
            end
            13: begin
                int c = 0;
                for (int i = 31; i >= 0 && a[i]; i--) c++;
                r = 32'(c);
            end
            default: r = '0;
        endcase
    endtask

    task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] sh);
        logic [31:0] er;
        logic        eo;
        model(op, a, b, sh, er, eo);
        @(negedge clk);
        issue_vld = 1'b1;
        op_code   = 4'(op);
        opnd_a    = a;
        opnd_b    = b;
        shamt_imm = sh;
        @(posedge clk);
        #1;
        n_checks++;
        if (res_vld !== 1'b1 || res_data !== er || ovf_trap !== eo || rd_wen !== !eo) begin
            n_fails++;
            $display("FAIL %s (R2/R6) op=%0d a=%h b=%h sh=%0d: got data=%h ovf=%b wen=%b vld=%b, expected data=%h ovf=%b wen=%b vld=1",
                     req_of(op), op, a, b, sh, res_data, ovf_trap, rd_wen, res_vld, er, eo, !eo);
        end
    endtask

    task automatic check_quiet(input string tag, input logic want_zero_data);
        n_checks++;
        if (res_vld !== 1'b0 || ovf_trap !== 1'b0 || rd_wen !== 1'b0 ||
            (want_zero_data && res_data !== 32'h0)) begin
            n_fails++;
            $display("FAIL %s: got vld=%b ovf=%b wen=%b data=%h, expected vld=0 ovf=0 wen=0%s",
                     tag, res_vld, ovf_trap, rd_wen, res_data, want_zero_data ? " data=0" : "");
        end
    endtask

    logic [31:0] arith_vals [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                                    32'hFFFF_FFFF, 32'h4000_0001, 32'hC000_0000, 32'h1234_5678};
    logic [31:0] shift_vals [4] = '{32'h8000_0001, 32'h7F3C_A5E1, 32'hF0F0_1234, 32'h0000_FFFF};

    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check_quiet("R1 reset", 1'b1);
        @(negedge clk);
        rst = 1'b0;

        // R3 R4 R5 R6: all pairs of boundary values
        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run_op(op, arith_vals[i], arith_vals[j], 5'(i + j));

        // R2: idle cycle after a valid result
        @(negedge clk);
        issue_vld = 1'b0;
        @(posedge clk);
        #1;
        check_quiet("R2 idle", 1'b0);

        // R7 R8 R9: every amount, immediate forms with garbage in opnd_b,
        // register forms with garbage in opnd_b[31:5] and a different immediate
        for (int op = 4; op < 12; op++)
            for (int p = 0; p < 4; p++)
                for (int n = 0; n < 32; n++) begin
                    if (op < 8)
                        run_op(op, shift_vals[p], 32'hDEAD_BEE0 | 32'(31 - n), 5'(n));
                    else
                        run_op(op, shift_vals[p], {27'h5A5_A5A5, 5'(n)}, 5'(~n));
                end

        // R10 R11: every leading-bit position plus the all-equal operands
        for (int k = 0; k < 32; k++) begin
            logic [31:0] v;
            v = (32'h1 << k) | ((32'h1 << k) - 32'h1) & 32'h6B3D_29C5;
            run_op(12, v, 32'h0, 5'd0);
            run_op(13, ~v, 32'h0, 5'd0);
        end
        run_op(12, 32'h0000_0000, 32'h0, 5'd0);
        run_op(12, 32'hFFFF_FFFF, 32'h0, 5'd0);
        run_op(13, 32'hFFFF_FFFF, 32'h0, 5'd0);
        run_op(13, 32'h0000_0000, 32'h0, 5'd0);

        // R12 unused encodings
        for (int op = 14; op < 16; op++)
            for (int i = 0; i < 8; i++)
                run_op(op, arith_vals[i], arith_vals[7 - i], 5'(i));

        // R1 reset after an overflowing issue
        run_op(0, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);
        @(negedge clk);
        issue_vld = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check_quiet("R1 mid-run reset", 1'b1);
        @(negedge clk);
        rst = 1'b0;
        run_op(1, 32'h7FFF_FFFF, 32'h0000_0001, 5'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule